// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the device end of a three-wire serial nonvolatile memory port: chip select, serial clock, serial data in, and serial data out with its own output enable. Behind the port sits an 8192-bit storage array modelled in registers. An organisation input picks the access width. High selects 16-bit words and low selects 8-bit bytes.

The host frames every instruction with a start bit. It can read, erase a location, write a location, erase the whole array, write one value everywhere, set the write-enable latch or clear it. Reads keep streaming words for as long as the clock runs. A memory-changing instruction launches a self-timed program cycle, whose length is a parameter in system clocks. While the host holds chip select high, the data output reports whether that cycle has finished.

The serial clock and chip select are sampled by the system clock, so the serial clock must stay well below the system clock rate. Power-on is modelled by a synchronous reset.

Top module: `uwire_eeprom`

## Requirements
- R1: An instruction is a 1 start bit, a 2-bit opcode and an address field, all sampled on rising serial clock edges MSB first. The opcodes are 10 read, 11 erase and 01 write. Opcode 00 is a special group picked by the two top address-field bits: 11 enable writes, 00 disable writes, 10 erase all, 01 write all. The address field is WORD_AW+1 bits in word mode and WORD_AW+2 bits in byte mode, and its top bit is ignored.
- R2: org_i high gives 16-bit words and org_i low gives 8-bit bytes. In byte mode, even byte address 2k is bits 15:8 of word k and odd byte address 2k+1 is bits 7:0 of word k.
- R3: On a read, the rising edge that takes the last address bit turns the output on with a 0 dummy bit. Each following rising edge presents the next data bit, MSB first.
- R4: With chip select still high, a read carries on into the next address with no further dummy bit, and it wraps from the last address to 0.
- R5: After reset, writes are disabled. A write, erase, erase-all or write-all received while disabled leaves memory unchanged and starts no busy cycle, so no status appears on the next select.
- R6: Enable stays set until a disable instruction or reset. Reads return data whatever the enable state.
- R7: A program operation starts only if chip select falls after the last instruction bit and before another rising serial clock edge. If a further rising edge comes first, the operation is dropped.
- R8: Erase sets the addressed word or byte to all ones, and erase-all sets every bit to one. Write replaces the location without a prior erase, and write-all stores its data in every location.
- R9: A program cycle lasts PROG_CYCLES clocks. If chip select is raised while a cycle is running, or after a completed cycle whose status has not yet been cleared, the output turns on and shows 0 while busy and 1 once ready.
- R10: Clocking a 1 into data in while status is shown keeps the output on until the next falling serial clock edge, then turns it off.
- R11: An instruction that starts while a program cycle is running is ignored in full.
- R12: The output enable is low while chip select is low and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organisation: 1 = 16-bit words, 0 = 8-bit bytes |
| do_o | output | 1 | Serial data out or ready/busy status |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
The bench builds the block with WORD_AW = 3, which gives 8 words or 16 bytes, and PROG_CYCLES = 200. The small array lets every word and every byte be written and read back, and lets sequential reads run past the top address and wrap in both organisations. The 200-clock program cycle is long enough for a complete instruction to arrive while busy. It is still short enough that each of the many program cycles in the run can be waited out and its ready status checked.

// File: rtl/uwire_eeprom_pkg.sv
package uwire_eeprom_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_ARMED,
        ST_SKIP
    } state_e;

    typedef enum logic [1:0] {
        OP_WRITE,
        OP_ERASE,
        OP_ERAL,
        OP_WRAL
    } op_e;
endpackage

// File: rtl/uwire_eeprom_sync.sv
module uwire_eeprom_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] lvl_d, lvl_q, prev_d, prev_q;

    always_comb begin
        lvl_d  = in_i;
        prev_d = lvl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            lvl_q  <= lvl_d;
            prev_q <= prev_d;
        end
    end

    assign lvl_o  = lvl_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/uwire_eeprom_timer.sv
module uwire_eeprom_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/uwire_eeprom_array.sv
module uwire_eeprom_array #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic          fill_en_i,
    input  logic [AW-1:0] wr_idx_i,
    input  logic [15:0]   wr_mask_i,
    input  logic [15:0]   wr_data_i,
    input  logic [AW-1:0] rd_idx_i,
    output logic [15:0]   rd_data_o
);
    localparam int WORDS = 1 << AW;

    logic [15:0] rows [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_row
        logic [15:0] cell_q;
        logic        hit;
        assign hit = fill_en_i | (wr_en_i & (wr_idx_i == AW'(g)));
        always_ff @(posedge clk) begin
            if (hit) cell_q <= (cell_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
        end
        assign rows[g] = cell_q;
    end

    assign rd_data_o = rows[rd_idx_i];
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
    import uwire_eeprom_pkg::*;
#(
    parameter int WORD_AW     = 9,
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic org_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int BYTE_AW = WORD_AW + 1;
    localparam int AF16    = WORD_AW + 1;
    localparam int AF8     = WORD_AW + 2;
    localparam int LEN16   = 2 + AF16;
    localparam int LEN8    = 2 + AF8;
    localparam int SH_W    = LEN8;
    localparam int MAXB    = (SH_W > WORD_W) ? SH_W : WORD_W;
    localparam int CNT_W   = $clog2(MAXB + 1);

    typedef struct packed {
        state_e             st;
        logic               x16;
        logic [CNT_W-1:0]   cnt;
        logic [SH_W-1:0]    sh;
        logic [BYTE_AW-1:0] addr;
        op_e                op;
        logic [WORD_W-1:0]  wdata;
        logic               wen;
        logic               oe;
        logic               dout;
        logic               show;
        logic               stat;
        logic               hz_arm;
        logic               di_s;
    } ctl_t;

    ctl_t q, n;

    logic [1:0] pin_lvl, pin_prev;
    logic cs_lvl, cs_rise, cs_fall, sk_rise, sk_fall;
    logic busy, prog_go;
    logic mem_we, mem_fill;
    logic [WORD_AW-1:0] mem_idx, rd_idx;
    logic [WORD_W-1:0]  mem_mask, mem_data, rd_data;

    uwire_eeprom_sync #(.W(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .in_i   ({cs_i, sk_i}),
        .lvl_o  (pin_lvl),
        .prev_o (pin_prev)
    );

    assign cs_lvl  = pin_lvl[1];
    assign cs_rise = pin_lvl[1] & ~pin_prev[1];
    assign cs_fall = ~pin_lvl[1] & pin_prev[1];
    assign sk_rise = pin_lvl[0] & ~pin_prev[0];
    assign sk_fall = ~pin_lvl[0] & pin_prev[0];

    uwire_eeprom_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (prog_go),
        .busy_o  (busy)
    );

    uwire_eeprom_array #(.AW(WORD_AW)) u_array (
        .clk       (clk),
        .wr_en_i   (mem_we),
        .fill_en_i (mem_fill),
        .wr_idx_i  (mem_idx),
        .wr_mask_i (mem_mask),
        .wr_data_i (mem_data),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    logic [CNT_W-1:0]   cnt_inc, dw, cmd_len;
    logic [SH_W-1:0]    sh_nx;
    logic [1:0]         opc, sub;
    logic [BYTE_AW-1:0] fa, addr_nx;
    logic [WORD_W-1:0]  rword, half_mask, wdata16;
    logic [7:0]         rbyte;
    logic [3:0]         bidx;

    always_comb begin
        n        = q;
        n.di_s   = di_i;
        prog_go  = 1'b0;
        mem_we   = 1'b0;
        mem_fill = 1'b0;

        // location decode shared by reads and program operations
        rd_idx    = q.x16 ? q.addr[WORD_AW-1:0] : q.addr[BYTE_AW-1:1];
        mem_idx   = rd_idx;
        half_mask = q.x16 ? 16'hFFFF : (q.addr[0] ? 16'h00FF : 16'hFF00);
        wdata16   = q.x16 ? q.wdata : {2{q.wdata[7:0]}};
        mem_mask  = half_mask;
        mem_data  = 16'hFFFF;
        rbyte     = q.addr[0] ? rd_data[7:0] : rd_data[15:8];
        rword     = q.x16 ? rd_data : {8'h00, rbyte};
        bidx      = q.x16 ? (4'd15 - q.cnt[3:0]) : (4'd7 - q.cnt[3:0]);
        addr_nx   = q.x16 ? {1'b0, q.addr[WORD_AW-1:0] + 1'b1} : q.addr + 1'b1;

        // instruction field decode
        cnt_inc = q.cnt + 1'b1;
        dw      = q.x16 ? CNT_W'(16) : CNT_W'(8);
        cmd_len = q.x16 ? CNT_W'(LEN16) : CNT_W'(LEN8);
        sh_nx   = {q.sh[SH_W-2:0], q.di_s};
        opc     = q.x16 ? sh_nx[AF16+1:AF16] : sh_nx[AF8+1:AF8];
        sub     = q.x16 ? sh_nx[AF16-1:AF16-2] : sh_nx[AF8-1:AF8-2];
        fa      = q.x16 ? {1'b0, sh_nx[WORD_AW-1:0]} : sh_nx[BYTE_AW-1:0];

        if (!cs_lvl) begin
            n.st     = ST_IDLE;
            n.oe     = 1'b0;
            n.show   = 1'b0;
            n.hz_arm = 1'b0;
            if (cs_fall && q.st == ST_ARMED) begin
                prog_go = 1'b1;
                n.stat  = 1'b1;
                case (q.op)
                    OP_WRITE: begin mem_we = 1'b1; mem_data = wdata16; end
                    OP_ERASE: begin mem_we = 1'b1; end
                    OP_ERAL:  begin mem_fill = 1'b1; mem_mask = 16'hFFFF; end
                    default:  begin mem_fill = 1'b1; mem_mask = 16'hFFFF; mem_data = wdata16; end
                endcase
            end
        end else begin
            if (cs_rise) begin
                n.show = busy | q.stat;
                n.oe   = busy | q.stat;
            end
            if (sk_fall && q.hz_arm) begin
                n.oe     = 1'b0;
                n.show   = 1'b0;
                n.hz_arm = 1'b0;
                if (!busy) n.stat = 1'b0;
            end
            if (sk_rise) begin
                case (q.st)
                    ST_IDLE: begin
                        if (q.di_s) begin
                            if (q.show) n.hz_arm = 1'b1;
                            n.st    = busy ? ST_SKIP : ST_CMD;
                            n.cnt   = '0;
                            n.sh    = '0;
                            n.wdata = '0;
                            n.x16   = org_i;
                        end
                    end
                    ST_CMD: begin
                        n.sh  = sh_nx;
                        n.cnt = cnt_inc;
                        if (cnt_inc == cmd_len) begin
                            n.addr = fa;
                            n.cnt  = '0;
                            case (opc)
                                2'b10: begin
                                    n.st   = ST_READ;
                                    n.oe   = 1'b1;
                                    n.dout = 1'b0;
                                    n.show = 1'b0;
                                end
                                2'b11: begin
                                    n.op = OP_ERASE;
                                    n.st = q.wen ? ST_ARMED : ST_SKIP;
                                end
                                2'b01: begin
                                    n.op = OP_WRITE;
                                    n.st = ST_DATA;
                                end
                                default: begin
                                    case (sub)
                                        2'b11: begin n.wen = 1'b1; n.st = ST_SKIP; end
                                        2'b00: begin n.wen = 1'b0; n.st = ST_SKIP; end
                                        2'b10: begin
                                            n.op = OP_ERAL;
                                            n.st = q.wen ? ST_ARMED : ST_SKIP;
                                        end
                                        default: begin
                                            n.op = OP_WRAL;
                                            n.st = ST_DATA;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_DATA: begin
                        n.wdata = {q.wdata[WORD_W-2:0], q.di_s};
                        n.cnt   = cnt_inc;
                        if (cnt_inc == dw) n.st = q.wen ? ST_ARMED : ST_SKIP;
                    end
                    ST_READ: begin
                        n.dout = rword[bidx];
                        n.cnt  = cnt_inc;
                        if (cnt_inc == dw) begin
                            n.cnt  = '0;
                            n.addr = addr_nx;
                        end
                    end
                    ST_ARMED: n.st = ST_SKIP;
                    default:  n.st = q.st;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign do_oe_o = q.oe;
    assign do_o    = q.show ? ~busy : q.dout;
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk
    import uwire_eeprom_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   cs_lvl,
    input logic   busy,
    input logic   wen,
    input logic   arr_we,
    input logic   arr_fill,
    input state_e st,
    input logic   do_o,
    input logic   do_oe
);
    AST_HIZ_DESELECT: assert property (@(posedge clk) disable iff (rst)
        !cs_lvl |=> !do_oe); // R12

    AST_PROG_ON_CS_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(cs_lvl)); // R7

    AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wen)); // R5

    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(arr_we || arr_fill)); // R11

    AST_READ_DUMMY_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_CMD && st == ST_READ) |-> (do_oe && !do_o)); // R3
endmodule

bind uwire_eeprom uwire_eeprom_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_lvl   (cs_lvl),
    .busy     (busy),
    .wen      (q.wen),
    .arr_we   (mem_we),
    .arr_fill (mem_fill),
    .st       (q.st),
    .do_o     (do_o),
    .do_oe    (do_oe_o)
);

// File: tb/uwire_eeprom_test.sv
module uwire_eeprom_test;
    localparam int AW    = 3;
    localparam int PROG  = 200;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic do_o, do_oe_o;

    int checks = 0;
    int fails  = 0;
    logic last_o, last_oe;
    logic [15:0] model [WORDS];

    always #4 clk = ~clk;

    uwire_eeprom #(.WORD_AW(AW), .PROG_CYCLES(PROG)) uut (
        .clk     (clk),
        .rst     (rst),
        .cs_i    (cs),
        .sk_i    (sk),
        .di_i    (di),
        .org_i   (org),
        .do_o    (do_o),
        .do_oe_o (do_oe_o)
    );

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic b);
        di = b;
        tick(4);
        sk = 1'b1;
        tick(4);
        last_o  = do_o;
        last_oe = do_oe_o;
        sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int nb);
        for (int i = nb - 1; i >= 0; i--) bit_io(v[i]);
    endtask

    task automatic instr(input logic [1:0] opc, input logic [31:0] fld, input logic x16);
        org = x16;
        cs = 1'b1;
        tick(4);
        bit_io(1'b1);
        send({30'd0, opc}, 2);
        send(fld, x16 ? AW + 1 : AW + 2);
    endtask

    task automatic drop_cs();
        cs = 1'b0;
        tick(4);
    endtask

    // wait out a program cycle, confirm ready, clear the status with a dummy 1
    task automatic finish_prog(input string req);
        drop_cs();
        tick(PROG + 10);
        cs = 1'b1;
        tick(4);
        chk(req, {14'd0, do_oe_o, do_o}, 16'd3);
        bit_io(1'b1);
        drop_cs();
    endtask

    function automatic logic [15:0] exp_of(input int idx, input logic x16);
        logic [15:0] w;
        if (x16) return model[idx];
        w = model[idx >> 1];
        return (idx % 2 == 1) ? {8'h00, w[7:0]} : {8'h00, w[15:8]};
    endfunction

    task automatic rd_chk(input int start, input int count, input logic x16, input string req);
        int dwid = x16 ? 16 : 8;
        int span = x16 ? WORDS : 2 * WORDS;
        int idx  = start;
        logic [15:0] got;
        instr(2'b10, x16 ? (32'h8 | start) : (32'h10 | start), x16);
        chk("R3 dummy zero with output on", {14'd0, last_oe, last_o}, 16'd2);
        for (int w = 0; w < count; w++) begin
            got = '0;
            for (int b = 0; b < dwid; b++) begin
                bit_io(1'b0);
                got = {got[14:0], last_o};
            end
            chk(req, got, exp_of(idx, x16));
            idx = (idx + 1) % span;
        end
        drop_cs();
    endtask

    task automatic set_byte(input int b, input logic [7:0] v);
        if (b % 2 == 1) model[b >> 1][7:0]  = v;
        else            model[b >> 1][15:8] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R1..all): actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        chk("R12 output off after reset", {15'd0, do_oe_o}, 16'd0);

        // R5: erase-all while disabled -> no busy cycle, no status
        instr(2'b00, 32'h8, 1'b1);
        drop_cs();
        tick(8);
        cs = 1'b1;
        tick(4);
        chk("R5 no status after disabled erase-all", {15'd0, do_oe_o}, 16'd0);
        drop_cs();
        chk("R12 output off when deselected", {15'd0, do_oe_o}, 16'd0);

        // R6: enable, then erase-all with busy/ready status and hide (R9, R10)
        instr(2'b00, 32'hC, 1'b1);
        drop_cs();
        instr(2'b00, 32'h8, 1'b1);
        drop_cs();
        cs = 1'b1;
        tick(4);
        chk("R9 busy shows 0", {14'd0, do_oe_o, do_o}, 16'd2);
        tick(PROG);
        chk("R9 ready shows 1", {14'd0, do_oe_o, do_o}, 16'd3);
        bit_io(1'b1);
        chk("R10 output held until falling edge", {15'd0, last_oe}, 16'd1);
        tick(4);
        chk("R10 output off after falling edge", {15'd0, do_oe_o}, 16'd0);
        drop_cs();
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        rd_chk(0, WORDS + 2, 1'b1, "R8 erase-all gives ones / R4 wrap");

        // R1: write every word (address field top bit is don't-care)
        for (int i = 0; i < WORDS; i++) begin
            model[i] = 16'(((i + 1) * 16'h1234) ^ 16'h5A5A);
            instr(2'b01, (i % 2 == 1) ? (32'h8 | i) : i, 1'b1);
            send({16'd0, model[i]}, 16);
            finish_prog("R9 ready after write");
        end
        rd_chk(5, WORDS + 1, 1'b1, "R4 sequential wrap x16");
        rd_chk(2, 1, 1'b1, "R1 single word read");

        // R2: byte mode writes and reads
        instr(2'b01, 3, 1'b0);
        send(32'h3C, 8);
        finish_prog("R9 ready after byte write");
        set_byte(3, 8'h3C);
        instr(2'b01, 12, 1'b0);
        send(32'hC3, 8);
        finish_prog("R9 ready after byte write");
        set_byte(12, 8'hC3);
        rd_chk(0, 2 * WORDS + 2, 1'b0, "R2 byte-mode read / R4 wrap x8");
        rd_chk(1, 1, 1'b1, "R2 odd byte is low half");
        rd_chk(6, 1, 1'b1, "R2 even byte is high half");

        // R8: word erase and byte erase
        instr(2'b11, 2, 1'b1);
        finish_prog("R9 ready after erase");
        model[2] = 16'hFFFF;
        instr(2'b11, 9, 1'b0);
        finish_prog("R9 ready after byte erase");
        set_byte(9, 8'hFF);
        rd_chk(0, WORDS, 1'b1, "R8 erase sets ones");

        // R7: extra rising edge before cs falls drops the write
        instr(2'b01, 6, 1'b1);
        send(32'h0000, 16);
        bit_io(1'b0);
        drop_cs();
        tick(PROG + 10);
        cs = 1'b1;
        tick(4);
        chk("R7 late cs fall starts no cycle", {15'd0, do_oe_o}, 16'd0);
        drop_cs();
        rd_chk(6, 1, 1'b1, "R7 dropped write leaves word");

        // R11: instruction sent while busy is ignored
        instr(2'b01, 0, 1'b1);
        send(32'hBEEF, 16);
        drop_cs();
        model[0] = 16'hBEEF;
        instr(2'b11, 1, 1'b1);
        drop_cs();
        finish_prog("R9 ready after busy window");
        rd_chk(0, 2, 1'b1, "R11 erase during busy ignored");

        // R5/R6: disable, write attempt dropped, reads still work
        instr(2'b00, 32'h0, 1'b1);
        drop_cs();
        instr(2'b01, 3, 1'b1);
        send(32'h0F0F, 16);
        drop_cs();
        tick(PROG + 10);
        cs = 1'b1;
        tick(4);
        chk("R5 disabled write starts no cycle", {15'd0, do_oe_o}, 16'd0);
        drop_cs();
        rd_chk(3, 1, 1'b1, "R6 read while disabled / R5 unchanged");

        // R8: write-all in both widths
        instr(2'b00, 32'hC, 1'b1);
        drop_cs();
        instr(2'b00, 32'h4, 1'b1);
        send(32'h6B9D, 16);
        finish_prog("R9 ready after write-all");
        for (int i = 0; i < WORDS; i++) model[i] = 16'h6B9D;
        rd_chk(0, WORDS, 1'b1, "R8 write-all x16");
        instr(2'b00, 32'h8, 1'b0);
        send(32'h47, 8);
        finish_prog("R9 ready after byte write-all");
        for (int i = 0; i < WORDS; i++) model[i] = 16'h4747;
        rd_chk(0, WORDS, 1'b1, "R8 write-all x8");

        // R6: disable holds against erase-all
        instr(2'b00, 32'h0, 1'b1);
        drop_cs();
        instr(2'b00, 32'h8, 1'b1);
        drop_cs();
        tick(PROG + 10);
        rd_chk(4, 2, 1'b1, "R6 disable blocks erase-all");

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule